// File: doc/BRIEF.md
# BT.656 D1-to-CIF Decimator

This block takes one 8-bit BT.656 byte stream from a video decoder and reduces each full-resolution 720x576 interlaced frame to a 352x288 image. It finds the four-byte timing codes that mark where each line starts and ends, and ignores all blanking. It counts active lines across the whole frame and keeps only every second line. Inside a kept line it drops every second pixel while keeping the chroma samples with the luma they belong to. It then trims the same number of pixels from both ends of the line to reach the CIF width. Four instances serve four cameras, one each, ahead of a frame buffer.

The result leaves as a byte stream with valid/ready handshaking. Each output byte carries a start-of-line flag, a start-of-frame flag and the field bit of the line it came from. Back-pressure passes straight through to the input. While a byte waits at the output, the input is not accepted, so nothing is lost and nothing is repeated. In a system where the source cannot stall, the consumer must hold ready high.

Top module: `d1cif_decim`

## Requirements
- R1: The four bytes FF, 00, 00, XY form a timing code. In XY, bit 4 is H (0 = start of active line, 1 = end of active line), bit 5 is V (1 = vertical blanking) and bit 6 is F (field). Only bytes that follow a line-start code with V=0 count as active. Bytes in blanking, and every byte of a line with V=1, produce no output.
- R2: The active-line index is set to 0 at the line-start code of a V=0 line when the previous line-start code had V=1 and the current one has F=0. Each other V=0 line-start code adds one to the index. Until the first such frame start after reset, there is no output.
- R3: Only lines with an odd active-line index (1, 3, 5, ...) produce output. Lines with an even index produce none.
- R4: Active lines whose index is ACT_LINES or more produce no output.
- R5: Within a kept line, active bytes form 8-byte units counted from the line-start code. Offsets 0, 1, 2 and 5 of each unit (Cb, Y0, Cr, Y2) are forwarded in order. Offsets 3, 4, 6 and 7 are dropped.
- R6: The first CROP_PIX/2 units and the last CROP_PIX/2 units of the LINE_BYTES active bytes are dropped, and bytes beyond LINE_BYTES are ignored. A kept line therefore yields (LINE_BYTES/4 - 2*CROP_PIX)*2 bytes, which is 704 at the defaults.
- R7: out_sol is 1 on the first output byte of each kept line and 0 on every other byte. out_sof is 1 only on the first output byte of the line with index 1.
- R8: out_field equals the F bit of the line-start code of the line that the byte came from.
- R9: in_ready is 1 exactly when the output holds no byte or out_ready is 1. While out_valid is 1 and out_ready is 0, the output byte and its flags stay unchanged. Every kept byte leaves exactly once, in input order.
- R10: After reset, out_valid is 0, in_ready is 1 and frame sync is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle when in_valid is 1 |
| in_data | input | 8 | BT.656 byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Kept video byte |
| out_sol | output | 1 | First byte of an output line |
| out_sof | output | 1 | First byte of an output frame |
| out_field | output | 1 | Field bit of the source line |

## Verification
The bench builds the block with LINE_BYTES=48, ACT_LINES=6 and CROP_PIX=2. With these values a line has six 8-byte units, one unit is trimmed at each end, and a kept line yields 16 bytes. A whole frame then runs in a few hundred cycles. The small line limit lets frames with extra active lines drive the index past ACT_LINES. Kept lines fall in both fields, so the field bit is tested. Overlong lines test that bytes after LINE_BYTES are ignored, and random gaps and back-pressure test the handshake.

// File: rtl/d1cif_pkg.sv
package d1cif_pkg;
  localparam logic [7:0] SYNC_HI = 8'hFF;
  localparam logic [7:0] SYNC_LO = 8'h00;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tcode_t;

  typedef struct packed {
    logic [7:0] data;
    logic       sol;
    logic       sof;
    logic       field;
  } obeat_t;
endpackage

// File: rtl/d1cif_code_det.sv
module d1cif_code_det
  import d1cif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic [7:0] din,
  output logic       hit,
  output tcode_t     code
);
  logic [7:0] hist0, hist1, hist2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist0 <= '0;
      hist1 <= '0;
      hist2 <= '0;
    end else if (beat) begin
      hist2 <= hist1;
      hist1 <= hist0;
      hist0 <= din;
    end
  end

  // current byte is the code word when the three before it were the preamble
  assign hit  = beat && (hist2 == SYNC_HI) && (hist1 == SYNC_LO) && (hist0 == SYNC_LO);
  assign code = '{f: din[6], v: din[5], h: din[4]};
endmodule

// File: rtl/d1cif_line_trk.sv
module d1cif_line_trk
  import d1cif_pkg::*;
#(
  parameter int LINE_BYTES = 1440,
  parameter int ACT_LINES  = 576,
  localparam int BCW = $clog2(LINE_BYTES + 1),
  localparam int LW  = $clog2(ACT_LINES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           beat,
  input  logic           hit,
  input  tcode_t         code,
  output logic           data_byte,
  output logic [BCW-1:0] bcnt,
  output logic [LW-1:0]  idx,
  output logic           sync,
  output logic           field
);
  localparam logic [BCW-1:0] BCNT_END = BCW'(LINE_BYTES);
  localparam logic [LW-1:0]  IDX_SAT  = LW'(ACT_LINES);

  logic active;
  logic vprev;

  assign data_byte = beat && !hit && active && (bcnt != BCNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      vprev  <= 1'b0;
      bcnt   <= '0;
      idx    <= IDX_SAT;
      sync   <= 1'b0;
      field  <= 1'b0;
    end else if (beat) begin
      if (hit) begin
        if (!code.h) begin
          vprev <= code.v;
          if (!code.v) begin
            active <= 1'b1;
            bcnt   <= '0;
            field  <= code.f;
            if (vprev && !code.f) begin
              sync <= 1'b1;
              idx  <= '0;
            end else if (idx != IDX_SAT) begin
              idx <= idx + 1'b1;
            end
          end else begin
            active <= 1'b0;
          end
        end else begin
          active <= 1'b0;
        end
      end else if (data_byte) begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/d1cif_pix_sel.sv
module d1cif_pix_sel #(
  parameter int LINE_BYTES = 1440,
  parameter int ACT_LINES  = 576,
  parameter int CROP_PIX   = 4,
  localparam int BCW = $clog2(LINE_BYTES + 1),
  localparam int LW  = $clog2(ACT_LINES + 1)
) (
  input  logic           data_byte,
  input  logic [BCW-1:0] bcnt,
  input  logic [LW-1:0]  idx,
  input  logic           sync,
  output logic           keep,
  output logic           sol,
  output logic           sof
);
  localparam int CROP_UNITS = CROP_PIX / 2;
  localparam int UNITS      = LINE_BYTES / 8;
  localparam logic [BCW-1:0] FIRST_B = BCW'(CROP_UNITS * 8);
  localparam logic [BCW-1:0] END_B   = BCW'((UNITS - CROP_UNITS) * 8);

  logic line_ok, span_ok, phase_ok;

  assign line_ok = sync && idx[0] && (idx < LW'(ACT_LINES));
  assign span_ok = (bcnt >= FIRST_B) && (bcnt < END_B);

  always_comb begin
    unique case (bcnt[2:0])
      3'd0, 3'd1, 3'd2, 3'd5: phase_ok = 1'b1;
      default:                phase_ok = 1'b0;
    endcase
  end

  assign keep = data_byte && line_ok && span_ok && phase_ok;
  assign sol  = keep && (bcnt == FIRST_B);
  assign sof  = sol && (idx == LW'(1));
endmodule

// File: rtl/d1cif_out_reg.sv
module d1cif_out_reg
  import d1cif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  obeat_t din,
  input  logic   o_ready,
  output logic   o_valid,
  output obeat_t o_beat,
  output logic   in_ready
);
  assign in_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_beat  <= '0;
    end else if (in_ready) begin
      o_valid <= take;
      if (take) o_beat <= din;
    end
  end
endmodule

// File: rtl/d1cif_decim.sv
module d1cif_decim
  import d1cif_pkg::*;
#(
  parameter int LINE_BYTES = 1440,
  parameter int ACT_LINES  = 576,
  parameter int CROP_PIX   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sol,
  output logic       out_sof,
  output logic       out_field
);
  localparam int BCW = $clog2(LINE_BYTES + 1);
  localparam int LW  = $clog2(ACT_LINES + 1);

  logic           beat, hit, data_byte, synced, field;
  logic           keep, sol, sof;
  tcode_t         code;
  logic [BCW-1:0] bcnt;
  logic [LW-1:0]  idx;
  obeat_t         nb, ob;

  assign beat = in_valid && in_ready;

  d1cif_code_det u_det (
    .clk(clk), .rst_n(rst_n), .beat(beat), .din(in_data), .hit(hit), .code(code)
  );

  d1cif_line_trk #(.LINE_BYTES(LINE_BYTES), .ACT_LINES(ACT_LINES)) u_trk (
    .clk(clk), .rst_n(rst_n), .beat(beat), .hit(hit), .code(code),
    .data_byte(data_byte), .bcnt(bcnt), .idx(idx), .sync(synced), .field(field)
  );

  d1cif_pix_sel #(.LINE_BYTES(LINE_BYTES), .ACT_LINES(ACT_LINES), .CROP_PIX(CROP_PIX)) u_sel (
    .data_byte(data_byte), .bcnt(bcnt), .idx(idx), .sync(synced),
    .keep(keep), .sol(sol), .sof(sof)
  );

  assign nb = '{data: in_data, sol: sol, sof: sof, field: field};

  d1cif_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .take(keep), .din(nb), .o_ready(out_ready),
    .o_valid(out_valid), .o_beat(ob), .in_ready(in_ready)
  );

  assign out_data  = ob.data;
  assign out_sol   = ob.sol;
  assign out_sof   = ob.sof;
  assign out_field = ob.field;
endmodule

// File: rtl/d1cif_checker.sv
module d1cif_checker #(
  parameter int LINE_BYTES = 1440,
  parameter int CROP_PIX   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sol,
  input logic       out_sof,
  input logic       out_field,
  input logic       synced
);
  localparam int OLB = (LINE_BYTES / 4 - 2 * CROP_PIX) * 2;

  int line_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_cnt <= 0;
    else if (out_valid && out_ready) line_cnt <= out_sol ? 1 : line_cnt + 1;
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sol)
                                && $stable(out_sof) && $stable(out_field));

  a_r9_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r7_sof_on_sol: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol);

  a_r2_quiet_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !out_valid);

  a_r6_line_width: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_sol |-> line_cnt < OLB);
endmodule

bind d1cif_decim d1cif_checker #(.LINE_BYTES(LINE_BYTES), .CROP_PIX(CROP_PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof),
  .out_field(out_field), .synced(synced)
);

// File: tb/d1cif_decim_bench.sv
`timescale 1ns/1ps
module d1cif_decim_bench;
  localparam int LB  = 48;
  localparam int AL  = 6;
  localparam int CP  = 2;
  localparam int CU  = CP / 2;
  localparam int OLB = (LB / 4 - 2 * CP) * 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_sol, out_sof, out_field;
  logic [7:0] out_data;

  d1cif_decim #(.LINE_BYTES(LB), .ACT_LINES(AL), .CROP_PIX(CP)) u_d1cif_decim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sol(out_sol), .out_sof(out_sof), .out_field(out_field)
  );

  always #2.5 clk = ~clk;

  logic [10:0] expq[$];
  int vectors = 0, fails = 0, got_total = 0;
  int ready_mode = 0, gap_mode = 0;
  logic [15:0] lf = 16'hACE1;
  bit st_prev = 0;
  logic [10:0] st_val;
  bit m_sync = 0, m_vprev = 0;
  int m_idx = 0;
  bit done = 0;

  function automatic bit rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic cycle(input logic v, input logic [7:0] d, output bit acc);
    logic [10:0] e, g;
    @(negedge clk);
    g = {out_data, out_sol, out_sof, out_field};
    if (st_prev) begin
      vectors++;
      if (!out_valid || g != st_val) begin
        fails++;
        $display("FAIL R9 stalled output changed: got v=%b %h exp v=1 %h", out_valid, g, st_val);
      end
    end
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = rnd();
      default: out_ready = rnd() & rnd();
    endcase
    #1;
    if (out_valid && out_ready) begin
      vectors++;
      got_total++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected output byte: got %h exp none", g);
      end else begin
        e = expq.pop_front();
        if (g[10:3] != e[10:3]) begin
          fails++; $display("FAIL R5 data: got %h exp %h", g[10:3], e[10:3]);
        end else if (g[2:1] != e[2:1]) begin
          fails++; $display("FAIL R7 sol/sof: got %b exp %b", g[2:1], e[2:1]);
        end else if (g[0] != e[0]) begin
          fails++; $display("FAIL R8 field: got %b exp %b", g[0], e[0]);
        end
      end
    end
    st_prev = out_valid && !out_ready;
    st_val  = g;
    in_valid = v;
    in_data  = d;
    #1;
    acc = v && in_ready;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit acc;
    if (gap_mode != 0 && rnd() && rnd()) cycle(1'b0, 8'h00, acc);
    do cycle(1'b1, b, acc); while (!acc);
  endtask

  task automatic send_line(input bit f, input bit v, input int nact);
    logic [7:0] xy;
    bit keep_line;
    int ph;
    logic [7:0] b;
    xy = 8'h80 | (8'(f) << 6) | (8'(v) << 5);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(xy | 8'h10);
    for (int i = 0; i < 4; i++) send_byte((i % 2 == 0) ? 8'h80 : 8'h10);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(xy);
    if (!v) begin
      if (m_vprev && !f) begin m_sync = 1; m_idx = 0; end
      else m_idx++;
    end
    m_vprev = v;
    keep_line = !v && m_sync && (m_idx % 2 == 1) && (m_idx < AL);
    for (int p = 0; p < nact; p++) begin
      b = 8'(16 + (p * 7 + m_idx * 13 + int'(f) * 5) % 200);
      ph = p % 8;
      if (keep_line && p < LB && p >= CU * 8 && p < (LB / 8 - CU) * 8 &&
          (ph == 0 || ph == 1 || ph == 2 || ph == 5))
        expq.push_back({b, p == CU * 8, (p == CU * 8) && (m_idx == 1), f});
      send_byte(b);
    end
  endtask

  task automatic send_frame(input int n0, input int n1, input int nact);
    for (int i = 0; i < 2; i++) send_line(1'b0, 1'b1, nact);
    for (int i = 0; i < n0; i++) send_line(1'b0, 1'b0, nact);
    for (int i = 0; i < 2; i++) send_line(1'b1, 1'b1, nact);
    for (int i = 0; i < n1; i++) send_line(1'b1, 1'b0, nact);
  endtask

  task automatic phase_check(input string tag, input int start, input int exp_delta);
    bit acc;
    int guard = 0;
    while (expq.size() != 0 && guard < 4000) begin cycle(1'b0, 8'h00, acc); guard++; end
    for (int i = 0; i < 6; i++) cycle(1'b0, 8'h00, acc);
    vectors++;
    if (got_total - start != exp_delta || expq.size() != 0) begin
      fails++;
      $display("FAIL %s output byte count: got %0d exp %0d (left %0d)", tag,
               got_total - start, exp_delta, expq.size());
    end
  endtask

  initial begin
    int s;
    repeat (4) @(negedge clk);
    // R10: reset state
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: got valid=%b ready=%b exp valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    // R2: active lines before any frame start give nothing
    s = got_total;
    send_line(1'b0, 1'b0, LB); send_line(1'b0, 1'b0, LB);
    phase_check("R2", s, 0);
    // R1: vertical blanking lines give nothing
    s = got_total;
    send_line(1'b0, 1'b1, LB); send_line(1'b1, 1'b1, LB);
    phase_check("R1", s, 0);
    // R3/R8: full frame, kept lines in both fields
    s = got_total;
    send_frame(3, 3, LB);
    phase_check("R3", s, 3 * OLB);
    // R4: extra lines past the limit, random gaps and ready
    ready_mode = 1; gap_mode = 1;
    s = got_total;
    send_frame(4, 4, LB);
    phase_check("R4", s, 3 * OLB);
    // R9: heavy back-pressure
    ready_mode = 2; gap_mode = 0;
    s = got_total;
    send_frame(3, 3, LB);
    phase_check("R9", s, 3 * OLB);
    // R6: overlong lines, extra bytes ignored
    ready_mode = 1;
    s = got_total;
    send_frame(3, 3, LB + 8);
    phase_check("R6", s, 3 * OLB);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule